// File: doc/BRIEF.md
# Serial Receive Word Flag Controller

This block is the receive-side holding stage of a synchronous serial port that runs either with one slot per frame (normal mode) or with several time slots per frame (network mode). A shift stage outside the block delivers each finished word as a one-cycle strobe. The strobe carries the word and a marker that says whether a frame sync was seen while that word was shifted in. The block moves accepted words into a holding register and keeps three status flags: word-available, overrun and first-slot. It also drives a data interrupt and an error interrupt.

A processor reads the holding register and the status word over a small read-only register bus. The address is `rd_addr`, and `rd_en` marks an access; `rd_data` is combinational from the current state. Reading the holding register empties it. The overrun flag stays set until a two-step sequence completes: first a status read that sees the flag set, then a holding-register read.

Top module: `ser_rx_flags`

## Requirements
- R1: After reset the status word reads 0 and both interrupt outputs are low.
- R2: While `rx_enable` is high, a word strobe with the holding register empty stores the word and sets word-available (status bit 0) at the next edge. The word reads back at address 0. An address-0 read clears word-available at the next edge.
- R3: `irq_rx` is high exactly while `rx_irq_en` is high and word-available is set.
- R4: A word strobe that arrives while the holding register is full, with no address-0 read in the same cycle, sets overrun (status bit 1). The stored word is kept and the incoming word is dropped.
- R5: An address-0 read that is not preceded by a status read seeing overrun set leaves overrun set.
- R6: A status read at address 1 that sees overrun set arms the clear. Further status reads keep it armed, and the next address-0 read clears overrun.
- R7: `irq_err` is high exactly while `err_irq_en` is high and overrun is set.
- R8: In network mode, status bit 2 holds the frame-sync marker of the word last stored. It is 1 for a first-slot word and 0 for any other slot.
- R9: In normal mode, status bit 2 reads 1 after any word has been stored, whatever the marker.
- R10: While `rx_enable` is low, word strobes are ignored and status bit 2 reads 0.
- R11: Status bits above bit 2 always read 0.
- R12: A word strobe in the same cycle as an address-0 read returns the old word on that read. The new word is stored with word-available set, and overrun does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Receiver enable |
| net_mode | input | 1 | 1 = network (multi-slot) mode, 0 = normal mode |
| rx_irq_en | input | 1 | Data interrupt enable |
| err_irq_en | input | 1 | Overrun interrupt enable |
| word_valid | input | 1 | One-cycle strobe: a complete word is ready |
| word_data | input | W | Word from the shift stage |
| word_fsync | input | 1 | Frame sync seen during this word |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | 0 = holding register, 1 = status word |
| rd_data | output | W | Read data (combinational) |
| irq_rx | output | 1 | Data interrupt request |
| irq_err | output | 1 | Overrun interrupt request |

## Verification
The capture path is driven with single words into an empty register and with back-to-back words that collide with an unread word. These two patterns separate a clean load from an overrun, and the collision also shows which word is kept. A strobe that coincides with a data read checks that an emptying read beats the collision. Read orderings (data only, status then data, status twice then data) show that only the armed sequence clears overrun. Marker patterns of 1 and 0 in each mode, and strobes with the receiver off, tell the two first-slot rules apart from the gating.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  localparam logic [1:0] ADDR_HOLD = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam int         FLAG_N    = 3;
  localparam int         BIT_AVAIL = 0;
  localparam int         BIT_OVR   = 1;
  localparam int         BIT_FIRST = 2;

  // a strobe is taken when enabled and the register is empty or being emptied
  function automatic logic take_word(input logic strobe, input logic en,
                                     input logic avail, input logic hold_rd);
    return strobe & en & (~avail | hold_rd);
  endfunction

  function automatic logic collide(input logic strobe, input logic en,
                                   input logic avail, input logic hold_rd);
    return strobe & en & avail & ~hold_rd;
  endfunction

  // first-slot marker stored with a word: always 1 with one slot per frame
  function automatic logic first_mark(input logic netm, input logic fs);
    return netm ? fs : 1'b1;
  endfunction

  function automatic logic [FLAG_N-1:0] pack_flags(input logic avail, input logic ovr,
                                                    input logic first, input logic en);
    logic [FLAG_N-1:0] f;
    f            = '0;
    f[BIT_AVAIL] = avail;
    f[BIT_OVR]   = ovr;
    f[BIT_FIRST] = first & en;
    return f;
  endfunction
endpackage

// File: rtl/ser_rx_capture.sv
module ser_rx_capture
  import ser_rx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         hold_rd,
  input  logic         net_mode,
  input  logic         word_fsync,
  input  logic [W-1:0] word_data,
  output logic         avail_q,
  output logic         first_q,
  output logic [W-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      first_q <= 1'b0;
      hold_q  <= '0;
    end else if (load) begin
      avail_q <= 1'b1;
      first_q <= first_mark(net_mode, word_fsync);
      hold_q  <= word_data;
    end else if (hold_rd) begin
      avail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_rx_overrun.sv
module ser_rx_overrun (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_evt,
  input  logic stat_rd,
  input  logic hold_rd,
  output logic ovr_q,
  output logic arm_q,
  output logic ovr_clr
);
  assign ovr_clr = hold_rd & arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;

      if (stat_rd)      arm_q <= ovr_q;
      else if (ovr_clr) arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_rx_flags.sv
module ser_rx_flags
  import ser_rx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_enable,
  input  logic         net_mode,
  input  logic         rx_irq_en,
  input  logic         err_irq_en,
  input  logic         word_valid,
  input  logic [W-1:0] word_data,
  input  logic         word_fsync,
  input  logic         rd_en,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq_rx,
  output logic         irq_err
);
  localparam int PAD = W - FLAG_N;

  logic hold_rd, stat_rd, load, ovr_evt;
  logic avail_q, first_q, ovr_q, arm_q, ovr_clr;
  logic [W-1:0] hold_q;
  logic [FLAG_N-1:0] flags;

  assign hold_rd = rd_en & (rd_addr == ADDR_HOLD);
  assign stat_rd = rd_en & (rd_addr == ADDR_STAT);
  assign load    = take_word(word_valid, rx_enable, avail_q, hold_rd);
  assign ovr_evt = collide(word_valid, rx_enable, avail_q, hold_rd);

  ser_rx_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(load), .hold_rd(hold_rd),
    .net_mode(net_mode), .word_fsync(word_fsync), .word_data(word_data),
    .avail_q(avail_q), .first_q(first_q), .hold_q(hold_q)
  );

  ser_rx_overrun u_ovr (
    .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .stat_rd(stat_rd),
    .hold_rd(hold_rd), .ovr_q(ovr_q), .arm_q(arm_q), .ovr_clr(ovr_clr)
  );

  assign flags = pack_flags(avail_q, ovr_q, first_q, rx_enable);

  always_comb begin
    if (rd_addr == ADDR_HOLD)      rd_data = hold_q;
    else if (rd_addr == ADDR_STAT) rd_data = {{PAD{1'b0}}, flags};
    else                           rd_data = '0;
  end

  assign irq_rx  = rx_irq_en & avail_q;
  assign irq_err = err_irq_en & ovr_q;
endmodule

// File: rtl/ser_rx_flags_chk.sv
module ser_rx_flags_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_enable,
  input logic         word_valid,
  input logic         err_irq_en,
  input logic         hold_rd,
  input logic         stat_rd,
  input logic         avail_q,
  input logic         ovr_q,
  input logic         arm_q,
  input logic [W-1:0] hold_q,
  input logic [W-1:0] rd_data,
  input logic         irq_err
);
  // R2
  avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && word_valid |=> avail_q);

  // R2
  avail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rd && !word_valid |=> !avail_q);

  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && word_valid && avail_q && !hold_rd |=> ovr_q);

  // R4
  keep_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable && word_valid && avail_q && !hold_rd |=> $stable(hold_q));

  // R5
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !(hold_rd && arm_q) |=> ovr_q);

  // R7
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) && err_irq_en |-> irq_err);

  // R10
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable && !avail_q && word_valid |=> !avail_q);

  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> rd_data[W-1:3] == '0);
endmodule

bind ser_rx_flags ser_rx_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .word_valid(word_valid),
  .err_irq_en(err_irq_en), .hold_rd(hold_rd), .stat_rd(stat_rd),
  .avail_q(avail_q), .ovr_q(ovr_q), .arm_q(arm_q), .hold_q(hold_q),
  .rd_data(rd_data), .irq_err(irq_err)
);

// File: tb/ser_rx_flags_test.sv
module ser_rx_flags_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b0, net_mode = 1'b0, rx_irq_en = 1'b0, err_irq_en = 1'b0;
  logic word_valid = 1'b0, word_fsync = 1'b0, rd_en = 1'b0;
  logic [W-1:0] word_data = '0;
  logic [1:0] rd_addr = 2'd0;
  logic [W-1:0] rd_data;
  logic irq_rx, irq_err;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ser_rx_flags #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .net_mode(net_mode),
    .rx_irq_en(rx_irq_en), .err_irq_en(err_irq_en), .word_valid(word_valid),
    .word_data(word_data), .word_fsync(word_fsync), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // one-cycle word strobe, optionally with a holding-register read in the same cycle
  task automatic push(input logic [W-1:0] d, input logic fs, input logic with_rd,
                      output logic [W-1:0] rd_val);
    @(negedge clk);
    word_valid = 1'b1; word_data = d; word_fsync = fs;
    rd_en = with_rd; rd_addr = 2'd0;
    #1 rd_val = rd_data;
    @(negedge clk);
    word_valid = 1'b0; rd_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    rd(2'd1, v);
    check("R1 status", v, 16'h0000);
    check("R1 irq", {14'd0, irq_rx, irq_err}, 16'h0000);
  endtask

  task automatic t_normal;
    logic [W-1:0] v, x;
    rx_enable = 1'b1; net_mode = 1'b0; rx_irq_en = 1'b1;
    push(16'hA5A5, 1'b0, 1'b0, x);
    rd(2'd1, v);
    check("R2 R9 R11 status after word", v, 16'h0005);
    check("R3 irq_rx", {15'd0, irq_rx}, 16'h0001);
    rd(2'd0, v);
    check("R2 word readback", v, 16'hA5A5);
    rd(2'd1, v);
    check("R2 avail cleared", v, 16'h0004);
    check("R3 irq_rx low", {15'd0, irq_rx}, 16'h0000);
  endtask

  task automatic t_network;
    logic [W-1:0] v, x;
    net_mode = 1'b1;
    push(16'h1111, 1'b1, 1'b0, x);
    rd(2'd1, v);
    check("R8 first slot", v, 16'h0005);
    rd(2'd0, v);
    push(16'h2222, 1'b0, 1'b0, x);
    rd(2'd1, v);
    check("R8 other slot", v, 16'h0001);
    rd(2'd0, v);
    check("R8 data", v, 16'h2222);
  endtask

  task automatic t_overrun;
    logic [W-1:0] v, x;
    err_irq_en = 1'b1;
    push(16'h3333, 1'b0, 1'b0, x);
    push(16'h4444, 1'b1, 1'b0, x);
    check("R7 irq_err on overrun", {15'd0, irq_err}, 16'h0001);
    rd(2'd0, v);
    check("R4 old word kept", v, 16'h3333);
    check("R5 overrun held after bare read", {15'd0, irq_err}, 16'h0001);
    push(16'h5555, 1'b1, 1'b0, x);
    rd(2'd1, v);
    check("R4 status overrun+avail", v, 16'h0007);
    rd(2'd1, v);
    rd(2'd0, v);
    check("R6 data", v, 16'h5555);
    rd(2'd1, v);
    check("R6 overrun cleared", v, 16'h0004);
    check("R7 irq_err low", {15'd0, irq_err}, 16'h0000);
  endtask

  task automatic t_same_cycle;
    logic [W-1:0] v, x;
    push(16'h6666, 1'b1, 1'b0, x);
    push(16'h7777, 1'b0, 1'b1, x);
    check("R12 read returns old", x, 16'h6666);
    rd(2'd1, v);
    check("R12 no overrun", v, 16'h0001);
    rd(2'd0, v);
    check("R12 new word stored", v, 16'h7777);
  endtask

  task automatic t_disabled;
    logic [W-1:0] v, x;
    push(16'h8888, 1'b1, 1'b0, x);
    rd(2'd0, v);
    rx_enable = 1'b0;
    rd(2'd1, v);
    check("R10 first flag masked", v, 16'h0000);
    push(16'h9999, 1'b1, 1'b0, x);
    rx_enable = 1'b1;
    rd(2'd1, v);
    check("R10 strobe ignored", v, 16'h0004);
    rd(2'd0, v);
    check("R10 data unchanged", v, 16'h8888);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal();
    t_network();
    t_overrun();
    t_same_cycle();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule